// File: doc/BRIEF.md
# ADC Register Front-End Controller

This block is the register-side controller for a successive-approximation converter. A host uses a 32-bit, word-addressed bus to pick an input channel, set the resolution, averaging and continuous mode, start a calibration, and collect results. The analog core and the conversion sequencer sit outside the block. The front-end gives the sequencer a start pulse with a channel number and a snapshot of the configuration. It then takes the sequencer's done strobe and data word.

A write to the channel register is the conversion trigger. One reserved channel code stops the converter instead. A completion flag in the status register goes high when a result has been captured or when a calibration ends. An interrupt output follows that flag, gated by an enable bit in the channel register. Calibration is a one-shot request. It runs for a fixed number of cycles and then clears its own request bit. A failure flag reports a channel write that arrived while calibration was running.

Top module: `adc_regfront`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and no start, abort or calibration pulse is driven.
- R2: Register offsets are 0x00 channel control, 0x08 status, 0x0C result, 0x14 configuration, 0x18 general control and 0x1C general status.
  - A channel-control write with bits [4:0] not equal to 0x1F drives `conv_start` high for exactly one cycle, with `conv_chan` equal to those bits.
  - The same write sets status bit 1 (active) and clears status bit 0 (complete).
- R3: A channel-control write with code 0x1F starts nothing and clears status bit 1. It pulses `conv_abort` for one cycle only if a conversion was active.
- R4: A `conv_done` strobe during a single-shot conversion captures the result, sets status bit 0 and clears status bit 1.
- R5: `irq` is 1 exactly when status bit 0 and channel-control bit 7 are both 1.
- R6: The result register returns the captured word masked by configuration bits [3:2]:
  - 00 keeps the low 8 bits;
  - 01 keeps the low 10 bits;
  - 10 or 11 keeps the low 12 bits.
- R7: Reading the result register clears status bit 0. Reading the status register does not clear it.
- R8: Writes to configuration bits [3:2], general-control bit 5 (averaging) or bit 6 (continuous) take effect from the next start. While a conversion is active, `conv_res`, `conv_avg` and `conv_cont` do not change.
- R9: With general-control bit 6 set when a conversion started, a `conv_done` strobe sets status bit 0 and starts the next conversion in the same cycle, leaving status bit 1 set.
- R10: Writing general-control bit 7 starts calibration:
  - it pulses `cal_go` once, aborts any active conversion, and makes general-status bit 0 and general-control bit 7 read 1;
  - CAL_LAT+1 cycles after the write, both bits clear themselves and status bit 0 sets.
- R11: A channel-control write during calibration starts no conversion and sets general-status bit 1. The next calibration start clears that bit.
- R12: A read at an unaligned address or above 0x30 sets `bus_err` with `bus_rdata` 0. An aligned, unmapped offset up to 0x30 reads 0 with no error.
- R13: `conv_done` while no conversion is active changes neither the status nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | Read rejected, valid with `bus_rdata` |
| conv_start | output | 1 | One-cycle conversion launch to the sequencer |
| conv_abort | output | 1 | One-cycle cancel of the active conversion |
| conv_chan | output | 5 | Channel of the current conversion |
| conv_res | output | 2 | Resolution snapshot for the current conversion |
| conv_avg | output | 1 | Averaging snapshot for the current conversion |
| conv_cont | output | 1 | Continuous-mode snapshot for the current conversion |
| cal_go | output | 1 | One-cycle calibration launch to the sequencer |
| conv_done | input | 1 | Sequencer result strobe |
| conv_data | input | DATA_W | Sequencer result word |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest states to reach are the overlaps:
- a channel write landing inside the calibration window;
- configuration changes made mid-conversion, which must not reach the sequencer until the next start.

The stimulus starts a conversion and rewrites the resolution and averaging fields before the done strobe. It then checks that both the snapshot ports and the masking of the captured result still follow the old setting, and that the following conversion picks up the new one. For calibration, the bench issues the channel write right after the calibration request, while the fixed-latency window is still open. It confirms that no start pulse appears, that the failure bit is set, and that a second calibration clears it.

// File: rtl/adc_rf_pkg.sv
package adc_rf_pkg;

    localparam logic [7:0] OFF_CHCTL  = 8'h00;
    localparam logic [7:0] OFF_STAT   = 8'h08;
    localparam logic [7:0] OFF_RESULT = 8'h0C;
    localparam logic [7:0] OFF_CFG    = 8'h14;
    localparam logic [7:0] OFF_GCTL   = 8'h18;
    localparam logic [7:0] OFF_GSTAT  = 8'h1C;
    localparam logic [7:0] OFF_LIMIT  = 8'h30;

    localparam logic [4:0] CHAN_STOP  = 5'h1F;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CHCTL,
        RG_STAT,
        RG_RESULT,
        RG_CFG,
        RG_GCTL,
        RG_GSTAT
    } reg_id_e;

    typedef enum logic [1:0] {
        RES_8  = 2'b00,
        RES_10 = 2'b01,
        RES_12 = 2'b10
    } res_e;

endpackage

// File: rtl/adc_rf_decode.sv
module adc_rf_decode
    import adc_rf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           rid,
    output logic              ok
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(OFF_LIMIT);

    always_comb begin
        ok = (addr[1:0] == 2'b00) && (addr <= LIMIT);
        unique case (addr)
            ADDR_W'(OFF_CHCTL):  rid = RG_CHCTL;
            ADDR_W'(OFF_STAT):   rid = RG_STAT;
            ADDR_W'(OFF_RESULT): rid = RG_RESULT;
            ADDR_W'(OFF_CFG):    rid = RG_CFG;
            ADDR_W'(OFF_GCTL):   rid = RG_GCTL;
            ADDR_W'(OFF_GSTAT):  rid = RG_GSTAT;
            default:             rid = RG_NONE;
        endcase
    end
endmodule

// File: rtl/adc_rf_mask.sv
module adc_rf_mask #(
    parameter int DATA_W = 12
) (
    input  logic [1:0]        res,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int KEEP8  = (DATA_W < 8)  ? DATA_W : 8;
    localparam int KEEP10 = (DATA_W < 10) ? DATA_W : 10;

    int keep;

    always_comb begin
        case (res)
            2'b00:   keep = KEEP8;
            2'b01:   keep = KEEP10;
            default: keep = DATA_W;
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = din[i] & (i < keep);
    end
endmodule

// File: rtl/adc_regfront.sv
module adc_regfront
    import adc_rf_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 12,
    parameter int CAL_LAT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              conv_start,
    output logic              conv_abort,
    output logic [4:0]        conv_chan,
    output logic [1:0]        conv_res,
    output logic              conv_avg,
    output logic              conv_cont,
    output logic              cal_go,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              irq
);
    localparam int CW = (CAL_LAT > 1) ? $clog2(CAL_LAT) : 1;
    localparam logic [CW-1:0] CAL_LOAD = CW'(CAL_LAT - 1);

    typedef struct packed {
        logic              ie;
        logic [4:0]        chan;
        logic [1:0]        res;
        logic              avg;
        logic              cont;
        logic              cal;
        logic [CW-1:0]     calcnt;
        logic              calfail;
        logic              coco;
        logic              busy;
        logic [4:0]        act_chan;
        logic [1:0]        act_res;
        logic              act_avg;
        logic              act_cont;
        logic [DATA_W-1:0] result;
        logic [31:0]       rdata;
        logic              err;
        logic              start_p;
        logic              abort_p;
        logic              calgo_p;
    } st_t;

    st_t st_d, st_q;

    reg_id_e           rid;
    logic              acc_ok;
    logic [DATA_W-1:0] masked;

    adc_rf_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .rid  (rid),
        .ok   (acc_ok)
    );

    adc_rf_mask #(.DATA_W(DATA_W)) msk_i (
        .res  (st_q.act_res),
        .din  (conv_data),
        .dout (masked)
    );

    always_comb begin
        st_d         = st_q;
        st_d.start_p = 1'b0;
        st_d.abort_p = 1'b0;
        st_d.calgo_p = 1'b0;
        st_d.err     = 1'b0;
        st_d.rdata   = '0;

        // host read; a result read drops the complete flag
        if (bus_rd) begin
            if (!acc_ok) begin
                st_d.err = 1'b1;
            end else begin
                case (rid)
                    RG_CHCTL:  st_d.rdata = {24'd0, st_q.ie, 2'b00, st_q.chan};
                    RG_STAT:   st_d.rdata = {30'd0, st_q.busy, st_q.coco};
                    RG_RESULT: begin
                        st_d.rdata = 32'(st_q.result);
                        st_d.coco  = 1'b0;
                    end
                    RG_CFG:    st_d.rdata = {28'd0, st_q.res, 2'b00};
                    RG_GCTL:   st_d.rdata = {24'd0, st_q.cal, st_q.cont, st_q.avg, 5'd0};
                    RG_GSTAT:  st_d.rdata = {30'd0, st_q.calfail, st_q.cal};
                    default:   st_d.rdata = '0;
                endcase
            end
        end

        // calibration window
        if (st_q.cal) begin
            if (st_q.calcnt == '0) begin
                st_d.cal  = 1'b0;
                st_d.coco = 1'b1;
            end else begin
                st_d.calcnt = st_q.calcnt - 1'b1;
            end
        end

        // result capture
        if (conv_done && st_q.busy && !st_q.cal) begin
            st_d.result = masked;
            st_d.coco   = 1'b1;
            if (st_q.act_cont) begin
                st_d.start_p  = 1'b1;
                st_d.act_res  = st_q.res;
                st_d.act_avg  = st_q.avg;
                st_d.act_cont = st_q.cont;
            end else begin
                st_d.busy = 1'b0;
            end
        end

        // host write
        if (bus_wr && acc_ok) begin
            case (rid)
                RG_CHCTL: begin
                    st_d.ie   = bus_wdata[7];
                    st_d.chan = bus_wdata[4:0];
                    if (st_q.cal) begin
                        st_d.calfail = 1'b1;
                    end else begin
                        st_d.coco    = 1'b0;
                        st_d.abort_p = st_q.busy;
                        st_d.start_p = 1'b0;
                        if (bus_wdata[4:0] == CHAN_STOP) begin
                            st_d.busy = 1'b0;
                        end else begin
                            st_d.busy     = 1'b1;
                            st_d.start_p  = 1'b1;
                            st_d.act_chan = bus_wdata[4:0];
                            st_d.act_res  = st_q.res;
                            st_d.act_avg  = st_q.avg;
                            st_d.act_cont = st_q.cont;
                        end
                    end
                end
                RG_CFG: st_d.res = bus_wdata[3:2];
                RG_GCTL: begin
                    st_d.avg  = bus_wdata[5];
                    st_d.cont = bus_wdata[6];
                    if (bus_wdata[7] && !st_q.cal) begin
                        st_d.cal     = 1'b1;
                        st_d.calcnt  = CAL_LOAD;
                        st_d.calfail = 1'b0;
                        st_d.coco    = 1'b0;
                        st_d.busy    = 1'b0;
                        st_d.abort_p = st_q.busy;
                        st_d.start_p = 1'b0;
                        st_d.calgo_p = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_err    = st_q.err;
    assign conv_start = st_q.start_p;
    assign conv_abort = st_q.abort_p;
    assign conv_chan  = st_q.act_chan;
    assign conv_res   = st_q.act_res;
    assign conv_avg   = st_q.act_avg;
    assign conv_cont  = st_q.act_cont;
    assign cal_go     = st_q.calgo_p;
    assign irq        = st_q.coco & st_q.ie;

endmodule

// File: rtl/adc_regfront_chk.sv
module adc_regfront_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rd,
    input logic       bus_err,
    input logic       conv_start,
    input logic       conv_abort,
    input logic [1:0] conv_res,
    input logic       conv_avg,
    input logic       conv_cont,
    input logic       conv_done,
    input logic       cal_go,
    input logic       coco_q,
    input logic       busy_q,
    input logic       cal_q
);
    AST_ABORT_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> $past(busy_q)); // R3

    AST_COCO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coco_q) |-> ($past(conv_done) || $past(cal_q))); // R4

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !conv_start) |-> ($stable(conv_res) && $stable(conv_avg) && $stable(conv_cont))); // R8

    AST_CALGO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_go |=> !cal_go); // R10

    AST_NO_START_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        cal_q |-> !conv_start); // R11

    AST_ERR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_rd)); // R12
endmodule

bind adc_regfront adc_regfront_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_err    (bus_err),
    .conv_start (conv_start),
    .conv_abort (conv_abort),
    .conv_res   (conv_res),
    .conv_avg   (conv_avg),
    .conv_cont  (conv_cont),
    .conv_done  (conv_done),
    .cal_go     (cal_go),
    .coco_q     (st_q.coco),
    .busy_q     (st_q.busy),
    .cal_q      (st_q.cal)
);

// File: tb/adc_regfront_tb_top.sv
module adc_regfront_tb_top;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_err;
    logic              conv_start, conv_abort, conv_avg, conv_cont, cal_go, irq;
    logic [4:0]        conv_chan;
    logic [1:0]        conv_res;
    logic              conv_done = 1'b0;
    logic [DATA_W-1:0] conv_data = '0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [32:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    adc_regfront #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAL_LAT(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .conv_start(conv_start), .conv_abort(conv_abort),
        .conv_chan(conv_chan), .conv_res(conv_res), .conv_avg(conv_avg),
        .conv_cont(conv_cont), .cal_go(cal_go), .conv_done(conv_done),
        .conv_data(conv_data), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(logic [7:0] a, logic [31:0] d, logic e, string tag);
        @(negedge clk);
        exp_q.push_back({e, d});
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic done(logic [DATA_W-1:0] d);
        @(negedge clk);
        conv_done = 1'b1; conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // monitor: compare read results against scoreboard
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk("SB unexpected read", 32'd1, 32'd0);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " rdata"}, bus_rdata, e[31:0]);
                    chk({t, " err"}, {31'd0, bus_err}, {31'd0, e[32]});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 start", {31'd0, conv_start}, 32'd0);
        rd_exp(8'h00, 32'h0, 1'b0, "R1 chctl");
        rd_exp(8'h08, 32'h0, 1'b0, "R1 stat");
        rd_exp(8'h0C, 32'h0, 1'b0, "R1 result");
        rd_exp(8'h14, 32'h0, 1'b0, "R1 cfg");
        rd_exp(8'h18, 32'h0, 1'b0, "R1 gctl");
        rd_exp(8'h1C, 32'h0, 1'b0, "R1 gstat");

        // R2 start, 12-bit mode
        wr(8'h14, 32'h8);
        wr(8'h00, 32'h85);
        chk("R2 start pulse", {31'd0, conv_start}, 32'd1);
        chk("R2 chan", {27'd0, conv_chan}, 32'd5);
        chk("R8 res snapshot", {30'd0, conv_res}, 32'd2);
        @(negedge clk);
        chk("R2 single pulse", {31'd0, conv_start}, 32'd0);
        rd_exp(8'h08, 32'h2, 1'b0, "R2 active");

        // R8 config changes mid-conversion
        wr(8'h14, 32'h0);
        wr(8'h18, 32'h20);
        chk("R8 res held", {30'd0, conv_res}, 32'd2);
        chk("R8 avg held", {31'd0, conv_avg}, 32'd0);

        // R4 / R5 / R6 / R7
        done(12'hABC);
        chk("R5 irq on", {31'd0, irq}, 32'd1);
        rd_exp(8'h08, 32'h1, 1'b0, "R4 stat complete");
        rd_exp(8'h08, 32'h1, 1'b0, "R7 stat read keeps flag");
        rd_exp(8'h0C, 32'hABC, 1'b0, "R6 12-bit result");
        chk("R7 irq cleared", {31'd0, irq}, 32'd0);
        rd_exp(8'h08, 32'h0, 1'b0, "R7 flag cleared");

        // R13 stray done
        done(12'h123);
        rd_exp(8'h08, 32'h0, 1'b0, "R13 stat");
        rd_exp(8'h0C, 32'hABC, 1'b0, "R13 result");

        // R8 new settings on next start, R6 8-bit
        wr(8'h00, 32'h83);
        chk("R8 res new", {30'd0, conv_res}, 32'd0);
        chk("R8 avg new", {31'd0, conv_avg}, 32'd1);
        done(12'hABC);
        rd_exp(8'h0C, 32'hBC, 1'b0, "R6 8-bit result");

        // R6 10-bit, R5 masked interrupt
        wr(8'h14, 32'h4);
        wr(8'h00, 32'h02);
        done(12'hFFF);
        chk("R5 irq disabled", {31'd0, irq}, 32'd0);
        rd_exp(8'h08, 32'h1, 1'b0, "R5 stat set");
        rd_exp(8'h0C, 32'h3FF, 1'b0, "R6 10-bit result");

        // R2 write clears flag
        done(12'h000);
        wr(8'h00, 32'h82);
        wr(8'h00, 32'h81);
        chk("R2 abort on retrigger", {31'd0, conv_abort}, 32'd1);
        rd_exp(8'h08, 32'h2, 1'b0, "R2 flag cleared");

        // R3 stop
        wr(8'h00, 32'h1F);
        chk("R3 abort", {31'd0, conv_abort}, 32'd1);
        chk("R3 no start", {31'd0, conv_start}, 32'd0);
        rd_exp(8'h08, 32'h0, 1'b0, "R3 stopped");
        wr(8'h00, 32'h1F);
        chk("R3 no abort idle", {31'd0, conv_abort}, 32'd0);

        // R9 continuous
        wr(8'h18, 32'h40);
        wr(8'h00, 32'h84);
        chk("R9 cont snapshot", {31'd0, conv_cont}, 32'd1);
        done(12'h111);
        chk("R9 restart", {31'd0, conv_start}, 32'd1);
        chk("R9 irq", {31'd0, irq}, 32'd1);
        rd_exp(8'h08, 32'h3, 1'b0, "R9 stat");
        rd_exp(8'h0C, 32'h111, 1'b0, "R9 result");
        wr(8'h00, 32'h1F);
        wr(8'h18, 32'h00);

        // R10 calibration
        wr(8'h18, 32'h80);
        chk("R10 cal_go", {31'd0, cal_go}, 32'd1);
        rd_exp(8'h18, 32'h80, 1'b0, "R10 gctl busy");
        rd_exp(8'h1C, 32'h1, 1'b0, "R10 gstat busy");
        repeat (20) @(negedge clk);
        rd_exp(8'h18, 32'h0, 1'b0, "R10 self clear");
        rd_exp(8'h1C, 32'h0, 1'b0, "R10 gstat done");
        rd_exp(8'h08, 32'h1, 1'b0, "R10 complete");

        // R11 channel write during calibration
        wr(8'h18, 32'h80);
        wr(8'h00, 32'h85);
        chk("R11 no start", {31'd0, conv_start}, 32'd0);
        rd_exp(8'h1C, 32'h3, 1'b0, "R11 fail set");
        repeat (20) @(negedge clk);
        rd_exp(8'h1C, 32'h2, 1'b0, "R11 fail held");
        wr(8'h18, 32'h80);
        rd_exp(8'h1C, 32'h1, 1'b0, "R11 fail cleared");
        repeat (20) @(negedge clk);

        // R12 address checks
        rd_exp(8'h02, 32'h0, 1'b1, "R12 unaligned");
        rd_exp(8'h34, 32'h0, 1'b1, "R12 above limit");
        rd_exp(8'h30, 32'h0, 1'b0, "R12 limit ok");
        rd_exp(8'h20, 32'h0, 1'b0, "R12 unmapped");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("SB drained", exp_q.size(), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule